// File: doc/BRIEF.md
# Bi-phase Lighting-Bus Reply Transmitter

This block sends the one-byte reply frame of a two-wire lighting-control bus (DALI) on a serial line in bi-phase (Manchester) code. Each frame has three parts. It opens with a start bit that is always logical 1. Next come the eight data bits, most significant first. It closes with two stop bits during which the line stays high. Between frames the line rests high and the block sits in its receive state.

Software first writes the reply byte and the prescaler value N. It then arms the transmitter through a control write that carries two request bits, send-request and activate. A frame starts only if send-request is set before activate, or in the same write as activate. An activate that arrives without a pending send-request has no effect.

When the frame starts, the block latches the byte and the divider and clears the pending request. Every half-bit lasts (N+1)*16 clock cycles. After the second stop bit the block drops busy, returns to receive, and raises an interrupt flag. The flag stays set until software clears it.

Top module: `bpl_reply_tx`

## Requirements
- R1: After reset `line_o` is 1, `busy_o` is 0 and `irq_o` is 0. The line is 1 whenever `busy_o` is 0.
- R2: A write (`ctl_wr`=1) with both `wr_rts`=1 and `wr_rta`=1 while idle starts a frame. `busy_o` is 1 from the next cycle.
- R3: A write with only `wr_rts`=1 does not start a frame. A later write with only `wr_rta`=1 then starts one.
- R4: A write with `wr_rta`=1 is ignored when no send-request is pending and `wr_rts`=0. `busy_o` stays 0 and the line stays 1.
- R5: The first bit is logical 1, sent as a low half-bit followed by a high half-bit.
- R6: Next come the eight data bits, most significant first. A 1 is sent low then high, and a 0 is sent high then low, so a bi-phase decoder recovers the byte.
- R7: The last two bits are stop bits. The line is high for both halves of each.
- R8: Each half-bit lasts (N+1)*16 cycles, where N is `div_n` at the start write. `busy_o` stays 1 for exactly 22 half-bits.
- R9: At the edge where `busy_o` falls, `irq_o` becomes 1.
- R10: `irq_o` holds until a cycle with `flag_clr`=1 clears it. If the frame ends in the same cycle as a clear, the set wins.
- R11: The start consumes the send-request. After a frame, an activate-only write does not start a new frame.
- R12: While busy, control writes and changes to `reply_data` or `div_n` have no effect on the frame in progress. A send-request written while busy is not kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Control write strobe |
| wr_rts | input | 1 | Send-request bit of the control write |
| wr_rta | input | 1 | Activate bit of the control write |
| reply_data | input | DATA_W | Reply byte, latched at start |
| div_n | input | DIV_W | Prescaler value N, latched at start |
| flag_clr | input | 1 | Clears the interrupt flag |
| line_o | output | 1 | Serial bus line, idles high |
| busy_o | output | 1 | Frame in progress (0 = receive state) |
| irq_o | output | 1 | Frame-done interrupt flag |

## Verification
The start write is accepted at one edge, and `busy_o` and the first low half-bit appear right after that edge. Half-bit j then covers edges k+j*HB through k+(j+1)*HB-1, where HB=(N+1)*16. The bench therefore samples every half-bit on the falling edge at its midpoint, HB/2 edges into the half. Each frame ends with two samples: one on the falling edge after edge k+22*HB-1, where `busy_o` must still be 1, and one after edge k+22*HB, where `busy_o` must be 0 and `irq_o` must be 1. A flag clear is checked on the falling edge right after the edge that took it.

// File: rtl/bpl_reply_pkg.sv
package bpl_reply_pkg;

   typedef enum logic {
      LINK_RX = 1'b0,
      LINK_TX = 1'b1
   } link_state_t;

   function automatic int frame_len(input int data_w, input int stop_bits);
      return 1 + data_w + stop_bits;
   endfunction

endpackage

// File: rtl/bpl_halfbit_timer.sv
module bpl_halfbit_timer #(
   parameter int DIV_W = 8,
   parameter int OVS   = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div_i,
   output logic             tick_o
);
   localparam int OVS_LOG = (OVS < 2) ? 1 : $clog2(OVS);
   localparam int CNT_W   = DIV_W + OVS_LOG;

   initial begin
      assert (OVS >= 2) else $error("bpl_halfbit_timer: OVS must be at least 2");
      assert (DIV_W >= 1) else $error("bpl_halfbit_timer: DIV_W must be at least 1");
   end

   logic [CNT_W-1:0] limit;
   logic [CNT_W-1:0] cnt;

   generate
      if ((1 << OVS_LOG) == OVS) begin : g_pow2
         assign limit = {div_i, {OVS_LOG{1'b1}}};
      end else begin : g_mul
         logic [CNT_W-1:0] div_ext;
         assign div_ext = CNT_W'(div_i);
         assign limit   = (div_ext + CNT_W'(1)) * CNT_W'(OVS) - CNT_W'(1);
      end
   endgenerate

   assign tick_o = run && (cnt == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!run || tick_o) begin
         cnt <= '0;
      end else begin
         cnt <= cnt + CNT_W'(1);
      end
   end

endmodule

// File: rtl/bpl_reply_arm.sv
module bpl_reply_arm (
   input  logic clk,
   input  logic rst_n,
   input  logic ctl_wr,
   input  logic wr_rts,
   input  logic wr_rta,
   input  logic busy,
   output logic start_o,
   output logic rts_pend_o
);
   logic rts_q;
   logic accept;

   assign accept     = ctl_wr && !busy;
   assign start_o    = accept && wr_rta && (wr_rts || rts_q);
   assign rts_pend_o = rts_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rts_q <= 1'b0;
      end else if (start_o) begin
         rts_q <= 1'b0;
      end else if (accept && wr_rts) begin
         rts_q <= 1'b1;
      end
   end

endmodule

// File: rtl/bpl_reply_shifter.sv
module bpl_reply_shifter #(
   parameter int DATA_W    = 8,
   parameter int SR_W      = 16,
   parameter int STOP_BITS = 2,
   parameter int IDX_W     = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] data_i,
   input  logic              tick,
   input  logic              active,
   output logic              line_o,
   output logic              last_o,
   output logic [IDX_W-1:0]  bit_idx_o
);
   localparam int FRAME_BITS = bpl_reply_pkg::frame_len(DATA_W, STOP_BITS);
   localparam int CODED_BITS = 1 + DATA_W;
   localparam int PAD        = SR_W - FRAME_BITS;

   initial begin
      assert (PAD >= 0) else $error("bpl_reply_shifter: SR_W too small for the frame");
      assert ((1 << IDX_W) > FRAME_BITS) else $error("bpl_reply_shifter: IDX_W too small");
   end

   logic [SR_W-1:0]  sr;
   logic [SR_W-1:0]  image;
   logic             half;
   logic [IDX_W-1:0] idx;
   logic             coded;

   generate
      if (PAD > 0) begin : g_pad
         assign image = {1'b1, data_i, {STOP_BITS{1'b1}}, {PAD{1'b0}}};
      end else begin : g_exact
         assign image = {1'b1, data_i, {STOP_BITS{1'b1}}};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr   <= '0;
         half <= 1'b0;
         idx  <= '0;
      end else if (load) begin
         sr   <= image;
         half <= 1'b0;
         idx  <= '0;
      end else if (tick) begin
         if (!half) begin
            half <= 1'b1;
         end else begin
            half <= 1'b0;
            sr   <= {sr[SR_W-2:0], 1'b0};
            idx  <= idx + IDX_W'(1);
         end
      end
   end

   assign coded     = idx < IDX_W'(CODED_BITS);
   assign line_o    = !active ? 1'b1 :
                      coded   ? (half ? sr[SR_W-1] : ~sr[SR_W-1]) :
                                sr[SR_W-1];
   assign last_o    = tick && half && (idx == IDX_W'(FRAME_BITS - 1));
   assign bit_idx_o = idx;

endmodule

// File: rtl/bpl_reply_tx.sv
module bpl_reply_tx #(
   parameter int DATA_W    = 8,
   parameter int DIV_W     = 8,
   parameter int OVS       = 16,
   parameter int SR_W      = 16,
   parameter int STOP_BITS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_wr,
   input  logic              wr_rts,
   input  logic              wr_rta,
   input  logic [DATA_W-1:0] reply_data,
   input  logic [DIV_W-1:0]  div_n,
   input  logic              flag_clr,
   output logic              line_o,
   output logic              busy_o,
   output logic              irq_o
);
   import bpl_reply_pkg::*;

   localparam int FRAME_BITS = frame_len(DATA_W, STOP_BITS);
   localparam int IDX_W      = $clog2(FRAME_BITS + 1);

   initial begin
      assert (DATA_W >= 1) else $error("bpl_reply_tx: DATA_W must be at least 1");
      assert (STOP_BITS >= 1) else $error("bpl_reply_tx: STOP_BITS must be at least 1");
      assert (SR_W >= FRAME_BITS) else $error("bpl_reply_tx: SR_W below frame length");
   end

   link_state_t      state;
   logic [DIV_W-1:0] div_q;
   logic             start;
   logic             tick;
   logic             last;
   logic             rts_pend;
   logic [IDX_W-1:0] bit_idx;

   assign busy_o = (state == LINK_TX);

   bpl_reply_arm u_arm (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctl_wr     (ctl_wr),
      .wr_rts     (wr_rts),
      .wr_rta     (wr_rta),
      .busy       (busy_o),
      .start_o    (start),
      .rts_pend_o (rts_pend)
   );

   bpl_halfbit_timer #(
      .DIV_W (DIV_W),
      .OVS   (OVS)
   ) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (busy_o),
      .div_i  (div_q),
      .tick_o (tick)
   );

   bpl_reply_shifter #(
      .DATA_W    (DATA_W),
      .SR_W      (SR_W),
      .STOP_BITS (STOP_BITS),
      .IDX_W     (IDX_W)
   ) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (start),
      .data_i    (reply_data),
      .tick      (tick),
      .active    (busy_o),
      .line_o    (line_o),
      .last_o    (last),
      .bit_idx_o (bit_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= LINK_RX;
         div_q <= '0;
      end else if (start) begin
         state <= LINK_TX;
         div_q <= div_n;
      end else if (last) begin
         state <= LINK_RX;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_o <= 1'b0;
      end else if (last) begin
         irq_o <= 1'b1;
      end else if (flag_clr) begin
         irq_o <= 1'b0;
      end
   end

endmodule

// File: rtl/bpl_reply_tx_chk.sv
module bpl_reply_tx_chk #(
   parameter int DATA_W    = 8,
   parameter int STOP_BITS = 2,
   parameter int IDX_W     = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ctl_wr,
   input logic             wr_rts,
   input logic             wr_rta,
   input logic             flag_clr,
   input logic             line_o,
   input logic             busy_o,
   input logic             irq_o,
   input logic             rts_pend,
   input logic [IDX_W-1:0] bit_idx
);
   localparam int CODED_BITS = 1 + DATA_W;

   p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> line_o);

   p_both_bits_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && wr_rta && wr_rts && !busy_o) |=> busy_o);

   p_armed_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && wr_rta && rts_pend && !busy_o) |=> busy_o);

   p_lone_rta_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && wr_rta && !wr_rts && !rts_pend && !busy_o) |=> !busy_o);

   p_stop_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && (bit_idx >= IDX_W'(CODED_BITS))) |-> line_o);

   p_done_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> irq_o);

   p_flag_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && !flag_clr) |=> irq_o);

   p_no_restart_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && (bit_idx != '0)) |=> (!busy_o || (bit_idx != '0)));

endmodule

bind bpl_reply_tx bpl_reply_tx_chk #(
   .DATA_W    (DATA_W),
   .STOP_BITS (STOP_BITS),
   .IDX_W     (IDX_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ctl_wr   (ctl_wr),
   .wr_rts   (wr_rts),
   .wr_rta   (wr_rta),
   .flag_clr (flag_clr),
   .line_o   (line_o),
   .busy_o   (busy_o),
   .irq_o    (irq_o),
   .rts_pend (rts_pend),
   .bit_idx  (bit_idx)
);

// File: tb/sim_bpl_reply_tx.sv
module sim_bpl_reply_tx;

   logic       clk;
   logic       rst_n;
   logic       ctl_wr;
   logic       wr_rts;
   logic       wr_rta;
   logic [7:0] reply_data;
   logic [7:0] div_n;
   logic       flag_clr;
   logic       line_o;
   logic       busy_o;
   logic       irq_o;

   int checks   = 0;
   int failures = 0;

   bpl_reply_tx u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctl_wr     (ctl_wr),
      .wr_rts     (wr_rts),
      .wr_rta     (wr_rta),
      .reply_data (reply_data),
      .div_n      (div_n),
      .flag_clr   (flag_clr),
      .line_o     (line_o),
      .busy_o     (busy_o),
      .irq_o      (irq_o)
   );

   initial clk = 1'b0;
   always #10 clk = ~clk;

   task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   function automatic logic exp_half(input logic [7:0] d, input int j);
      int   b;
      logic v;
      b = j / 2;
      if (b == 0)      v = 1'b1;
      else if (b <= 8) v = d[8 - b];
      else             return 1'b1;
      return (j % 2 == 1) ? v : ~v;
   endfunction

   function automatic logic [8:0] decode(input logic [21:0] s);
      logic [7:0] d;
      logic       ok;
      ok = (s[21] == 1'b0) && (s[20] == 1'b1);
      for (int b = 1; b <= 8; b++) begin
         d[8 - b] = s[20 - 2*b];
         if (s[21 - 2*b] == s[20 - 2*b]) ok = 1'b0;
      end
      return {ok, d};
   endfunction

   task automatic ctl_write(input logic rts, input logic rta);
      @(negedge clk);
      ctl_wr = 1'b1;
      wr_rts = rts;
      wr_rta = rta;
      @(posedge clk);
      #1;
      ctl_wr = 1'b0;
      wr_rts = 1'b0;
      wr_rta = 1'b0;
   endtask

   task automatic clear_flag();
      @(negedge clk);
      flag_clr = 1'b1;
      @(negedge clk);
      flag_clr = 1'b0;
      chk("R10 flag cleared", irq_o, 0);
   endtask

   task automatic run_frame(input logic [7:0] d, input int n, input bit same_write,
                            input bit disturb, input bit hold_clr);
      int          hb;
      int          pre;
      logic [21:0] got;
      logic [21:0] exp;
      logic        busy_ok;
      logic [8:0]  dec;
      hb         = (n + 1) * 16;
      reply_data = d;
      div_n      = 8'(n);
      if (same_write) begin
         ctl_write(1'b1, 1'b1);
      end else begin
         ctl_write(1'b1, 1'b0);
         repeat (3) @(negedge clk);
         chk("R3 send-request alone starts nothing", busy_o, 0);
         ctl_write(1'b0, 1'b1);
      end
      reply_data = ~d;
      div_n      = 8'(n + 3);
      busy_ok    = 1'b1;
      pre        = 0;
      repeat (hb / 2) @(posedge clk);
      @(negedge clk);
      for (int j = 0; j < 22; j++) begin
         if (j > 0) begin
            repeat (hb - pre) @(posedge clk);
            @(negedge clk);
         end
         got[21 - j] = line_o;
         exp[21 - j] = exp_half(d, j);
         busy_ok     = busy_ok & busy_o;
         pre         = 0;
         if (hold_clr && j == 20) flag_clr = 1'b1;
         if (disturb && j == 6) begin
            ctl_wr = 1'b1;
            wr_rts = 1'b1;
            wr_rta = 1'b1;
            @(posedge clk);
            #1;
            ctl_wr = 1'b0;
            wr_rts = 1'b0;
            wr_rta = 1'b0;
            pre    = 1;
         end
      end
      chk("R5 start bit halves", {30'd0, got[21:20]}, {30'd0, exp[21:20]});
      chk("R6 data bit halves", {16'd0, got[19:4]}, {16'd0, exp[19:4]});
      chk("R7 stop bits high", {28'd0, got[3:0]}, 32'hF);
      dec = decode(got);
      chk("R6 decoded byte", {23'd0, dec}, {23'd0, 1'b1, d});
      chk("R8 busy through frame", busy_ok, 1);
      repeat (hb / 2 - 1) @(posedge clk);
      @(negedge clk);
      chk("R8 busy in last cycle", busy_o, 1);
      @(posedge clk);
      @(negedge clk);
      chk("R8 busy falls after 22 half-bits", busy_o, 0);
      chk("R9 flag set at frame end", irq_o, 1);
      chk("R1 line idles high", line_o, 1);
      if (hold_clr) begin
         @(posedge clk);
         @(negedge clk);
         chk("R10 clear applies after set", irq_o, 0);
         flag_clr = 1'b0;
      end
      if (disturb) begin
         ctl_write(1'b0, 1'b1);
         repeat (3) @(negedge clk);
         chk("R12 send-request written while busy not kept", busy_o, 0);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL R8 watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [7:0] rd;
      int         rn;
      bit         rs;
      void'($urandom(32'h5EED));
      rst_n      = 1'b0;
      ctl_wr     = 1'b0;
      wr_rts     = 1'b0;
      wr_rta     = 1'b0;
      reply_data = 8'h00;
      div_n      = 8'h00;
      flag_clr   = 1'b0;
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset line", line_o, 1);
      chk("R1 reset busy", busy_o, 0);
      chk("R1 reset flag", irq_o, 0);

      ctl_write(1'b0, 1'b1);
      repeat (4) @(negedge clk);
      chk("R4 lone activate busy", busy_o, 0);
      chk("R4 lone activate line", line_o, 1);

      run_frame(8'hA5, 0, 1'b1, 1'b0, 1'b0);
      clear_flag();
      run_frame(8'h3C, 1, 1'b0, 1'b0, 1'b0);
      clear_flag();

      ctl_write(1'b0, 1'b1);
      repeat (4) @(negedge clk);
      chk("R11 request consumed by start", busy_o, 0);

      run_frame(8'hC3, 0, 1'b1, 1'b1, 1'b0);
      clear_flag();
      run_frame(8'hFF, 2, 1'b1, 1'b0, 1'b1);
      run_frame(8'h00, 0, 1'b0, 1'b0, 1'b0);
      clear_flag();

      for (int i = 0; i < 8; i++) begin
         rd = 8'($urandom);
         rn = int'($urandom % 3);
         rs = 1'($urandom);
         run_frame(rd, rn, rs, 1'b0, 1'b0);
         clear_flag();
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule